// File: doc/BRIEF.md
# Dual-Read Single-Write Register Bank

This block is the integer register bank of a three-operand datapath. It keeps a set of general-purpose words (thirty-two words of 32 bits by default). Two read ports let the operand fetch stage pull both source operands in the same cycle. A single write port lets the writeback stage retire one result per clock.

Both read ports are purely combinational: the data follows the address within the same cycle, with no register in the path. The write port updates its target on the rising clock edge, and only while its enable is high. Entry 0 is a constant zero. It always reads as zero, and any write aimed at it is dropped without effect.

A synchronous reset clears every entry. The `BYPASS` parameter sets what a read returns when it targets the entry being written in the same cycle. With the default of 0 the read returns the stored word. With 1 it returns the incoming word. No port has a handshake: every port is a plain level that is sampled or driven each cycle, so the block never applies back-pressure.

Top module: `regfile_2r1w`

## Requirements
- R1: While `rst` is high at a rising edge, every entry is cleared. After that edge, every address reads 0 on both ports until the entry is written again.
- R2: When `wr_en` is high at a rising edge and `wr_addr` is nonzero, entry `wr_addr` takes `wr_data`. Both read ports return that value from the cycle after that edge.
- R3: When `wr_en` is low at a rising edge, no entry changes, whatever `wr_addr` and `wr_data` are.
- R4: Address 0 reads as 32'h0 on both ports at all times. A write with `wr_addr` equal to 0 changes no entry.
- R5: The two read ports are independent and combinational. Each port returns the entry selected by its own address in the same cycle that the address is applied, including when both ports select different entries or the same entry.
- R6: With `BYPASS`=0, a read of the entry being written in the same cycle returns the value stored before the edge.
- R7: With `BYPASS`=1, a read whose address equals a nonzero `wr_addr` while `wr_en` is high returns `wr_data` in that same cycle.
- R8: A write changes only the entry it addresses. All other entries keep their contents.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock; writes and reset act on its rising edge |
| rst | input | 1 | Synchronous reset, active high, clears all entries |
| rd_a_addr | input | ADDR_W (5) | Entry number for read port A |
| rd_a_data | output | DATA_W (32) | Word read through port A |
| rd_b_addr | input | ADDR_W (5) | Entry number for read port B |
| rd_b_data | output | DATA_W (32) | Word read through port B |
| wr_en | input | 1 | Write enable for the write port |
| wr_addr | input | ADDR_W (5) | Entry number to write |
| wr_data | input | DATA_W (32) | Word to write |

## Verification
A corrupted entry stays hidden until one of the read ports selects it. Because the reads are combinational, the fault then appears in that same cycle. A dropped or misdirected write appears on the first read of the target entry or of the entry hit by mistake, one edge after the write. The bench therefore sweeps every address on both ports after resets and writes, and it also reads random addresses every cycle, so that stale or stray state cannot remain unread for long.

// File: rtl/rf_pkg.sv
package rf_pkg;

  // Read behaviour when a read and a write meet on the same entry
  typedef enum logic {
    RD_STORED = 1'b0,
    RD_INCOMING = 1'b1
  } rf_collide_e;

  function automatic rf_collide_e collide_mode(input bit bypass);
    return bypass ? RD_INCOMING : RD_STORED;
  endfunction

endpackage

// File: rtl/rf_wr_decode.sv
module rf_wr_decode #(
  parameter int NUM_REGS = 32,
  localparam int ADDR_W = $clog2(NUM_REGS)
) (
  input  logic              wr_en,
  input  logic [ADDR_W-1:0] wr_addr,
  output logic [NUM_REGS-1:0] wr_sel
);

  // One-hot write select; entry 0 never selected
  for (genvar gi = 0; gi < NUM_REGS; gi++) begin : g_sel
    if (gi == 0) begin : g_zero
      assign wr_sel[gi] = 1'b0;
    end else begin : g_live
      assign wr_sel[gi] = wr_en && (wr_addr == ADDR_W'(gi));
    end
  end

endmodule

// File: rtl/rf_storage.sv
module rf_storage #(
  parameter int NUM_REGS = 32,
  parameter int DATA_W = 32
) (
  input  logic                             clk,
  input  logic                             rst,
  input  logic [NUM_REGS-1:0]              wr_sel,
  input  logic [DATA_W-1:0]                wr_data,
  output logic [NUM_REGS-1:0][DATA_W-1:0]  entries
);

  for (genvar gi = 0; gi < NUM_REGS; gi++) begin : g_ent
    if (gi == 0) begin : g_const
      assign entries[gi] = '0;
    end else begin : g_flop
      logic [DATA_W-1:0] word_q;
      always_ff @(posedge clk) begin
        if (rst) begin
          word_q <= '0;
        end else if (wr_sel[gi]) begin
          word_q <= wr_data;
        end
      end
      assign entries[gi] = word_q;
    end
  end

endmodule

// File: rtl/rf_rd_port.sv
module rf_rd_port
  import rf_pkg::*;
#(
  parameter int NUM_REGS = 32,
  parameter int DATA_W = 32,
  parameter bit BYPASS = 1'b0,
  localparam int ADDR_W = $clog2(NUM_REGS)
) (
  input  logic [NUM_REGS-1:0][DATA_W-1:0] entries,
  input  logic [ADDR_W-1:0]               rd_addr,
  input  logic                            wr_en,
  input  logic [ADDR_W-1:0]               wr_addr,
  input  logic [DATA_W-1:0]               wr_data,
  output logic [DATA_W-1:0]               rd_data
);

  localparam rf_collide_e MODE = collide_mode(BYPASS);

  logic [DATA_W-1:0] stored;
  logic              hit;

  always_comb begin
    stored = '0;
    for (int i = 0; i < NUM_REGS; i++) begin
      if (rd_addr == ADDR_W'(i)) stored = entries[i];
    end
  end

  assign hit = wr_en && (wr_addr == rd_addr) && (rd_addr != '0);

  if (MODE == RD_INCOMING) begin : g_fwd
    assign rd_data = hit ? wr_data : stored;
  end else begin : g_plain
    logic unused_fwd;
    assign unused_fwd = hit ^ (^wr_data);
    assign rd_data = stored;
  end

endmodule

// File: rtl/regfile_2r1w.sv
module regfile_2r1w #(
  parameter int NUM_REGS = 32,
  parameter int DATA_W = 32,
  parameter bit BYPASS = 1'b0,
  localparam int ADDR_W = $clog2(NUM_REGS)
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [ADDR_W-1:0] rd_a_addr,
  output logic [DATA_W-1:0] rd_a_data,
  input  logic [ADDR_W-1:0] rd_b_addr,
  output logic [DATA_W-1:0] rd_b_data,
  input  logic              wr_en,
  input  logic [ADDR_W-1:0] wr_addr,
  input  logic [DATA_W-1:0] wr_data
);

  localparam int NUM_RD = 2;

  logic [NUM_REGS-1:0]             wr_sel;
  logic [NUM_REGS-1:0][DATA_W-1:0] entries;
  logic [NUM_RD-1:0][ADDR_W-1:0]   rd_addr_v;
  logic [NUM_RD-1:0][DATA_W-1:0]   rd_data_v;

  rf_wr_decode #(.NUM_REGS(NUM_REGS)) u_dec (
    .wr_en  (wr_en),
    .wr_addr(wr_addr),
    .wr_sel (wr_sel)
  );

  rf_storage #(.NUM_REGS(NUM_REGS), .DATA_W(DATA_W)) u_store (
    .clk    (clk),
    .rst    (rst),
    .wr_sel (wr_sel),
    .wr_data(wr_data),
    .entries(entries)
  );

  assign rd_addr_v[0] = rd_a_addr;
  assign rd_addr_v[1] = rd_b_addr;

  for (genvar gp = 0; gp < NUM_RD; gp++) begin : g_rd
    rf_rd_port #(
      .NUM_REGS(NUM_REGS),
      .DATA_W  (DATA_W),
      .BYPASS  (BYPASS)
    ) u_port (
      .entries(entries),
      .rd_addr(rd_addr_v[gp]),
      .wr_en  (wr_en),
      .wr_addr(wr_addr),
      .wr_data(wr_data),
      .rd_data(rd_data_v[gp])
    );
  end

  assign rd_a_data = rd_data_v[0];
  assign rd_b_data = rd_data_v[1];

endmodule

// File: rtl/regfile_2r1w_chk.sv
module regfile_2r1w_chk #(
  parameter int ADDR_W = 5,
  parameter int DATA_W = 32,
  parameter bit BYPASS = 1'b0
) (
  input logic              clk,
  input logic              rst,
  input logic [ADDR_W-1:0] rd_a_addr,
  input logic [DATA_W-1:0] rd_a_data,
  input logic [ADDR_W-1:0] rd_b_addr,
  input logic [DATA_W-1:0] rd_b_data,
  input logic              wr_en,
  input logic [ADDR_W-1:0] wr_addr,
  input logic [DATA_W-1:0] wr_data
);

  logic fwd_a, fwd_b;
  assign fwd_a = BYPASS && wr_en && (wr_addr == rd_a_addr) && (rd_a_addr != '0);
  assign fwd_b = BYPASS && wr_en && (wr_addr == rd_b_addr) && (rd_b_addr != '0);

  AST_ZERO_A: assert property (@(posedge clk) disable iff (rst)
    (rd_a_addr == '0) |-> (rd_a_data == '0)); // R4
  AST_ZERO_B: assert property (@(posedge clk) disable iff (rst)
    (rd_b_addr == '0) |-> (rd_b_data == '0)); // R4
  AST_WRITE_LANDS_A: assert property (@(posedge clk) disable iff (rst)
    (wr_en && wr_addr != '0) |=>
      ((rd_a_addr == $past(wr_addr) && !fwd_a) -> (rd_a_data == $past(wr_data)))); // R2
  AST_WRITE_LANDS_B: assert property (@(posedge clk) disable iff (rst)
    (wr_en && wr_addr != '0) |=>
      ((rd_b_addr == $past(wr_addr) && !fwd_b) -> (rd_b_data == $past(wr_data)))); // R2
  AST_IDLE_HOLDS_A: assert property (@(posedge clk) disable iff (rst)
    ($past(!wr_en) && !$past(rst) && $stable(rd_a_addr) && !fwd_a) |-> $stable(rd_a_data)); // R3
  AST_CLEARED_A: assert property (@(posedge clk) disable iff (rst)
    ($past(rst) && !fwd_a) |-> (rd_a_data == '0)); // R1
  AST_CLEARED_B: assert property (@(posedge clk) disable iff (rst)
    ($past(rst) && !fwd_b) |-> (rd_b_data == '0)); // R1

endmodule

bind regfile_2r1w regfile_2r1w_chk #(
  .ADDR_W(ADDR_W),
  .DATA_W(DATA_W),
  .BYPASS(BYPASS)
) u_chk (
  .clk      (clk),
  .rst      (rst),
  .rd_a_addr(rd_a_addr),
  .rd_a_data(rd_a_data),
  .rd_b_addr(rd_b_addr),
  .rd_b_data(rd_b_data),
  .wr_en    (wr_en),
  .wr_addr  (wr_addr),
  .wr_data  (wr_data)
);

// File: tb/regfile_2r1w_bench.sv
`timescale 1ns/1ps
module regfile_2r1w_bench;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic [4:0]  rd_a_addr = '0, rd_b_addr = '0, wr_addr = '0;
  logic        wr_en = 1'b0;
  logic [31:0] wr_data = '0;
  logic [31:0] a_plain, b_plain, a_fwd, b_fwd;

  int n_cmp = 0;
  int n_bad = 0;
  bit done = 1'b0;
  logic [31:0] mdl [32];

  always #2.5 clk = ~clk;

  regfile_2r1w #(.BYPASS(1'b0)) u_regfile_2r1w (
    .clk(clk), .rst(rst),
    .rd_a_addr(rd_a_addr), .rd_a_data(a_plain),
    .rd_b_addr(rd_b_addr), .rd_b_data(b_plain),
    .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data)
  );

  regfile_2r1w #(.BYPASS(1'b1)) u_fwd (
    .clk(clk), .rst(rst),
    .rd_a_addr(rd_a_addr), .rd_a_data(a_fwd),
    .rd_b_addr(rd_b_addr), .rd_b_data(b_fwd),
    .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data)
  );

  task automatic cmp(input string tag, input string what,
                     input logic [31:0] act, input logic [31:0] exp);
    n_cmp++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s %s: actual %h expected %h", tag, what, act, exp);
    end
  endtask

  function automatic logic [31:0] expect_rd(input logic [4:0] ra, input bit fwd);
    if (ra == 0) return 32'h0;
    if (fwd && wr_en && wr_addr == ra) return wr_data;
    return mdl[ra];
  endfunction

  // drive one cycle, compare before the edge, then advance the model
  task automatic step(input string tag, input bit r, input bit we,
                      input logic [4:0] wa, input logic [31:0] wd,
                      input logic [4:0] ra, input logic [4:0] rb);
    rst = r; wr_en = we; wr_addr = wa; wr_data = wd;
    rd_a_addr = ra; rd_b_addr = rb;
    #1;
    cmp(tag, "plain A", a_plain, expect_rd(ra, 1'b0));
    cmp(tag, "plain B", b_plain, expect_rd(rb, 1'b0));
    cmp(tag, "fwd A",   a_fwd,   expect_rd(ra, 1'b1));
    cmp(tag, "fwd B",   b_fwd,   expect_rd(rb, 1'b1));
    @(posedge clk);
    if (r) begin
      for (int i = 0; i < 32; i++) mdl[i] = '0;
    end else if (we && wa != 0) begin
      mdl[wa] = wd;
    end
    @(negedge clk);
  endtask

  task automatic sweep(input string tag);
    for (int i = 0; i < 32; i++) step(tag, 1'b0, 1'b0, 5'd0, 32'h0, 5'(i), 5'(31 - i));
  endtask

  task automatic finish_up;
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  endtask

  initial begin
    #(200000 * 5);
    if (!done) begin
      n_cmp++; n_bad++;
      $display("FAIL watchdog: actual timeout expected completion");
      finish_up();
    end
  end

  initial begin
    for (int i = 0; i < 32; i++) mdl[i] = '0;
    repeat (3) @(posedge clk);
    @(negedge clk);
    // R1: reset state on every address
    step("R1", 1'b1, 1'b0, 5'd0, 32'h0, 5'd0, 5'd0);
    sweep("R1");
    // R2 / R8: fill every entry, then read them all back
    for (int i = 0; i < 32; i++)
      step("R8", 1'b0, 1'b1, 5'(i), 32'hC0DE_0000 + 32'(i * 7), 5'(i ^ 1), 5'((i + 3) % 32));
    sweep("R2");
    // R4: writes to entry 0 are dropped
    step("R4", 1'b0, 1'b1, 5'd0, 32'hFFFF_FFFF, 5'd0, 5'd0);
    step("R4", 1'b0, 1'b0, 5'd0, 32'h0, 5'd0, 5'd0);
    // R3: write enable low leaves the entry untouched
    step("R3", 1'b0, 1'b1, 5'd9, 32'h1234_5678, 5'd1, 5'd2);
    step("R3", 1'b0, 1'b0, 5'd9, 32'hDEAD_BEEF, 5'd9, 5'd9);
    step("R3", 1'b0, 1'b0, 5'd0, 32'h0, 5'd9, 5'd9);
    // R6 / R7: read and write on the same entry in one cycle
    step("R6", 1'b0, 1'b1, 5'd9, 32'hAAAA_5555, 5'd9, 5'd9);
    step("R7", 1'b0, 1'b1, 5'd17, 32'h0BAD_F00D, 5'd17, 5'd3);
    step("R7", 1'b0, 1'b1, 5'd0, 32'h7777_7777, 5'd0, 5'd17);
    // R5: ports select different and equal entries in one cycle
    step("R5", 1'b0, 1'b0, 5'd0, 32'h0, 5'd17, 5'd9);
    step("R5", 1'b0, 1'b0, 5'd0, 32'h0, 5'd31, 5'd31);
    // R1: reset in mid run, write present in the same cycle
    step("R1", 1'b1, 1'b1, 5'd4, 32'h4444_4444, 5'd4, 5'd5);
    sweep("R1");
    // mixed traffic
    for (int k = 0; k < 1500; k++)
      step("R5", ($urandom % 200) == 0, $urandom % 2, 5'($urandom), $urandom,
           5'($urandom), 5'($urandom));
    sweep("R8");
    done = 1'b1;
    finish_up();
  end

endmodule